// File: doc/BRIEF.md
# Narrow-to-Wide Bus Bridge Sequencer

This block sits on the slave side of a 16-bit backplane and lets the host there reach a 32-bit secondary bus. On the secondary bus it is the only master, so it never arbitrates. Each aligned 32-bit target transfer is built from two 16-bit host cycles. The bridge latches the address and the data halves between those two cycles and steers them to the right place. A 12-bit offset register, which software writes, supplies the upper target address bits. Host address bits 19..2 pass straight through to the target address.

The block accepts a host cycle only under three conditions: the address modifier is one of four standard-space data codes, the transfer is 16 bits wide, and host address bits 23..21 equal a 3-bit configured window value. Host address bit 20 then chooses between the offset register and a data access.

A write sequence and a read sequence are asymmetric. A write acknowledges its first half at once and runs the target write on its second half. A read runs the target read on its first half and answers its second half from a stored word. The acknowledge of the host cycle that starts the target transfer is held back until the target signals completion. Two indicator outputs give a one-cycle pulse: one for offset register writes and one for completed target transfers.

Top module: `narrow_wide_bridge`

## Requirements
- R1: A host cycle is ignored (no acknowledge, no target request) unless `host_am` is 0x39, 0x3A, 0x3D or 0x3E and `host_wide` is low.
- R2: A host cycle is ignored unless `host_addr[23:21]` equals `base_sel`.
- R3: An accepted write with `host_addr[20]`=1 loads the offset register from `host_wdata[15:4]`. Bits 3..0 are ignored. It acknowledges one cycle after the select, pulses `led_cfg` with that acknowledge, and leaves the data phase unchanged.
- R4: An accepted read with `host_addr[20]`=1 acknowledges one cycle after the select with `host_rdata`=0. The offset register cannot be read back.
- R5: The first write half (`host_addr[20]`=0) latches `host_addr[19:2]` and the data as the high word. It acknowledges one cycle after the select and raises no target request.
- R6: The second write half raises `tgt_req` with `tgt_we`=1. `tgt_addr` is {offset, latched addr[19:2], 2'b00} and `tgt_wdata` is {high word, this cycle's data}. `host_ack` follows in the cycle after `tgt_done` is sampled.
- R7: A read with no stored low word raises a target read at {offset, `host_addr[19:2]`, 2'b00}. It stores `tgt_rdata[15:0]` and acknowledges in the cycle after `tgt_done`, with `host_rdata`=`tgt_rdata[31:16]`.
- R8: The next read returns the stored low word one cycle after the select, with no target request, and clears the stored half.
- R9: A data read that arrives while a write half is held discards that half and acts as a first read half. A data write that arrives while a read low word is held acts as a first write half.
- R10: `tgt_req`, `tgt_addr` and `tgt_we` hold steady until `tgt_done`. A select that arrives while a target transfer is running is ignored, and each accepted cycle gets exactly one acknowledge.
- R11: `led_bus` pulses for one cycle together with the acknowledge that ends each target transfer.
- R12: After reset, all outputs are low, the offset register is 0, and no half is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_sel | input | 3 | Configured window value compared with host address bits 23..21 |
| host_sel | input | 1 | One-cycle strobe starting a host cycle |
| host_we | input | 1 | Host cycle is a write |
| host_wide | input | 1 | Host requests a 32-bit transfer (rejected) |
| host_am | input | 6 | Host address modifier |
| host_addr | input | 23 | Host address bits 23..1 |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid with host_ack |
| host_ack | output | 1 | One-cycle acknowledge |
| tgt_req | output | 1 | Target transfer request, held until tgt_done |
| tgt_we | output | 1 | Target transfer is a write |
| tgt_addr | output | 32 | Aligned target address |
| tgt_wdata | output | 32 | Target write data |
| tgt_rdata | input | 32 | Target read data, valid with tgt_done |
| tgt_done | input | 1 | Target completion strobe |
| led_cfg | output | 1 | Pulse on an offset register write |
| led_bus | output | 1 | Pulse on each completed target transfer |

## Verification
The hardest situation to reach is a select that arrives while a target transfer is still waiting for completion. The bench reaches it by holding off `tgt_done` for several cycles after a target read starts and strobing a write select in that gap. It then shows that the select left no trace: a later write pair produces a target word built only from its own two halves. The bench also mixes directions so that a read lands on a held write half, and it resets the block partway through a write pair.

// File: rtl/n2w_bridge_pkg.sv
package n2w_bridge_pkg;
    localparam int HALF_W  = 16;
    localparam int TGT_W   = 32;
    localparam int OFF_W   = 12;
    localparam int MAP_LO  = 2;
    localparam int MAP_W   = TGT_W - OFF_W - MAP_LO;
    localparam int CFG_BIT = MAP_W + MAP_LO;
    localparam int AM_W    = 6;

    typedef enum logic [1:0] {
        HALF_NONE    = 2'b00,
        HALF_WR_HELD = 2'b01,
        HALF_RD_HELD = 2'b10
    } half_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_TGT  = 1'b1
    } seq_e;

    typedef struct packed {
        seq_e               state;
        half_e              half;
        logic [MAP_W-1:0]   lat_addr;
        logic [HALF_W-1:0]  hi_word;
        logic [HALF_W-1:0]  lo_word;
        logic [HALF_W-1:0]  rdata;
        logic               ack;
        logic               led_cfg;
        logic               led_bus;
        logic               tgt_req;
        logic               tgt_we;
        logic [TGT_W-1:0]   tgt_addr;
        logic [TGT_W-1:0]   tgt_wdata;
    } seq_regs_t;
endpackage

// File: rtl/n2w_decode.sv
module n2w_decode
    import n2w_bridge_pkg::*;
#(
    parameter int ADDR_MSB = 23,
    parameter int N_AM     = 4,
    parameter logic [N_AM*AM_W-1:0] AM_LIST = {6'h39, 6'h3A, 6'h3D, 6'h3E}
) (
    input  logic [AM_W-1:0]             am,
    input  logic                        wide,
    input  logic [ADDR_MSB:1]           addr,
    input  logic [ADDR_MSB-CFG_BIT-1:0] base_sel,
    output logic                        acc_ok,
    output logic                        cfg_sel
);
    logic [N_AM-1:0] am_match;

    for (genvar i = 0; i < N_AM; i++) begin : g_am
        assign am_match[i] = (am == AM_LIST[i*AM_W +: AM_W]);
    end

    logic win_hit;
    assign win_hit = (addr[ADDR_MSB:CFG_BIT+1] == base_sel);
    assign acc_ok  = (|am_match) && !wide && win_hit;
    assign cfg_sel = acc_ok && addr[CFG_BIT];
endmodule

// File: rtl/n2w_offset_reg.sv
module n2w_offset_reg
    import n2w_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HALF_W-1:0] data_in,
    output logic [OFF_W-1:0]  offset
);
    logic [OFF_W-1:0] off_d, off_q;
    logic unused_low;
    assign unused_low = ^data_in[HALF_W-OFF_W-1:0];

    always_comb begin
        off_d = off_q;
        if (load) off_d = data_in[HALF_W-1 -: OFF_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) off_q <= '0;
        else        off_q <= off_d;
    end

    assign offset = off_q;
endmodule

// File: rtl/n2w_seq.sv
module n2w_seq
    import n2w_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic              acc_ok,
    input  logic              cfg_sel,
    input  logic [MAP_W-1:0]  map_addr,
    input  logic [HALF_W-1:0] wdata,
    input  logic [OFF_W-1:0]  offset,
    input  logic              tgt_done,
    input  logic [TGT_W-1:0]  tgt_rdata,
    output logic              off_load,
    output seq_regs_t         regs
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.ack     = 1'b0;
        r_d.led_cfg = 1'b0;
        r_d.led_bus = 1'b0;
        off_load    = 1'b0;
        unique case (r_q.state)
            SEQ_IDLE: begin
                if (sel && acc_ok) begin
                    if (cfg_sel) begin
                        r_d.ack = 1'b1;
                        if (we) begin
                            off_load    = 1'b1;
                            r_d.led_cfg = 1'b1;
                        end else begin
                            r_d.rdata = '0;
                        end
                    end else if (we) begin
                        if (r_q.half == HALF_WR_HELD) begin
                            r_d.tgt_req   = 1'b1;
                            r_d.tgt_we    = 1'b1;
                            r_d.tgt_addr  = {offset, r_q.lat_addr, {MAP_LO{1'b0}}};
                            r_d.tgt_wdata = {r_q.hi_word, wdata};
                            r_d.state     = SEQ_TGT;
                        end else begin
                            r_d.lat_addr = map_addr;
                            r_d.hi_word  = wdata;
                            r_d.half     = HALF_WR_HELD;
                            r_d.ack      = 1'b1;
                        end
                    end else begin
                        if (r_q.half == HALF_RD_HELD) begin
                            r_d.rdata = r_q.lo_word;
                            r_d.half  = HALF_NONE;
                            r_d.ack   = 1'b1;
                        end else begin
                            r_d.half     = HALF_NONE;
                            r_d.tgt_req  = 1'b1;
                            r_d.tgt_we   = 1'b0;
                            r_d.tgt_addr = {offset, map_addr, {MAP_LO{1'b0}}};
                            r_d.state    = SEQ_TGT;
                        end
                    end
                end
            end
            SEQ_TGT: begin
                if (tgt_done) begin
                    r_d.tgt_req = 1'b0;
                    r_d.ack     = 1'b1;
                    r_d.led_bus = 1'b1;
                    r_d.state   = SEQ_IDLE;
                    if (r_q.tgt_we) begin
                        r_d.half = HALF_NONE;
                    end else begin
                        r_d.rdata   = tgt_rdata[TGT_W-1:HALF_W];
                        r_d.lo_word = tgt_rdata[HALF_W-1:0];
                        r_d.half    = HALF_RD_HELD;
                    end
                end
            end
            default: r_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= SEQ_IDLE;
            r_q.half  <= HALF_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs = r_q;
endmodule

// File: rtl/narrow_wide_bridge.sv
module narrow_wide_bridge
    import n2w_bridge_pkg::*;
#(
    parameter int ADDR_MSB = 23,
    localparam int BASE_W  = ADDR_MSB - CFG_BIT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BASE_W-1:0]   base_sel,
    input  logic                host_sel,
    input  logic                host_we,
    input  logic                host_wide,
    input  logic [AM_W-1:0]     host_am,
    input  logic [ADDR_MSB:1]   host_addr,
    input  logic [HALF_W-1:0]   host_wdata,
    output logic [HALF_W-1:0]   host_rdata,
    output logic                host_ack,
    output logic                tgt_req,
    output logic                tgt_we,
    output logic [TGT_W-1:0]    tgt_addr,
    output logic [TGT_W-1:0]    tgt_wdata,
    input  logic [TGT_W-1:0]    tgt_rdata,
    input  logic                tgt_done,
    output logic                led_cfg,
    output logic                led_bus
);
    logic             acc_ok, cfg_sel, off_load;
    logic [OFF_W-1:0] offset;
    seq_regs_t        regs;
    logic             unused_a1;
    assign unused_a1 = ^host_addr[MAP_LO-1:1];

    n2w_decode #(.ADDR_MSB(ADDR_MSB)) dec_i (
        .am       (host_am),
        .wide     (host_wide),
        .addr     (host_addr),
        .base_sel (base_sel),
        .acc_ok   (acc_ok),
        .cfg_sel  (cfg_sel)
    );

    n2w_offset_reg off_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (off_load),
        .data_in (host_wdata),
        .offset  (offset)
    );

    n2w_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (host_sel),
        .we        (host_we),
        .acc_ok    (acc_ok),
        .cfg_sel   (cfg_sel),
        .map_addr  (host_addr[CFG_BIT-1:MAP_LO]),
        .wdata     (host_wdata),
        .offset    (offset),
        .tgt_done  (tgt_done),
        .tgt_rdata (tgt_rdata),
        .off_load  (off_load),
        .regs      (regs)
    );

    assign host_rdata = regs.rdata;
    assign host_ack   = regs.ack;
    assign tgt_req    = regs.tgt_req;
    assign tgt_we     = regs.tgt_we;
    assign tgt_addr   = regs.tgt_addr;
    assign tgt_wdata  = regs.tgt_wdata;
    assign led_cfg    = regs.led_cfg;
    assign led_bus    = regs.led_bus;
endmodule

// File: rtl/n2w_bridge_sva.sv
module n2w_bridge_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        host_ack,
    input logic        tgt_req,
    input logic        tgt_we,
    input logic [31:0] tgt_addr,
    input logic        tgt_done,
    input logic        led_cfg,
    input logic        led_bus
);
    // R10: request and its attributes stay put until completion
    assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req && !tgt_done |=> tgt_req && $stable(tgt_addr) && $stable(tgt_we));

    // R6 / R7: completion produces the host acknowledge next cycle
    assert_ack_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req && tgt_done |=> host_ack && !tgt_req);

    // R7: no acknowledge while a target transfer is still open
    assert_no_ack_in_flight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> !tgt_req);

    // R6: target addresses are word aligned
    assert_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |-> tgt_addr[1:0] == 2'b00);

    // R11: bus indicator only with the closing acknowledge of a transfer
    assert_led_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        led_bus |-> host_ack && $past(tgt_req && tgt_done));

    // R3: config indicator only with an acknowledge and no target activity
    assert_led_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        led_cfg |-> host_ack && !tgt_req && !led_bus);
endmodule

bind narrow_wide_bridge n2w_bridge_sva sva_i (.*);

// File: tb/narrow_wide_bridge_tb.sv
`timescale 1ns/1ps
module narrow_wide_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  base_sel = 3'b101;
    logic        host_sel = 1'b0, host_we = 1'b0, host_wide = 1'b0;
    logic [5:0]  host_am = 6'h39;
    logic [23:1] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_ack, tgt_req, tgt_we, led_cfg, led_bus;
    logic [31:0] tgt_addr, tgt_wdata;
    logic [31:0] tgt_rdata = '0;
    logic        tgt_done = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    narrow_wide_bridge dut_i (.*);

    // kind: 0 = ignored, 1 = immediate acknowledge, 2 = target transfer
    typedef struct packed {
        logic        we;
        logic        wide;
        logic [5:0]  am;
        logic [23:0] addr;
        logic [15:0] wd;
        logic [1:0]  kind;
        logic [31:0] taddr;
        logic [31:0] twd;
        logic [31:0] trd;
        logic        chk_rd;
        logic [15:0] rd;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,6'h39,24'hB00000,16'hABCF,2'd1,32'h0,32'h0,32'h0,1'b0,16'h0},        // R3 offset=ABC
        '{1'b0,1'b0,6'h39,24'hB00000,16'h0,2'd1,32'h0,32'h0,32'h0,1'b1,16'h0000},        // R4
        '{1'b1,1'b0,6'h39,24'hA12344,16'h1111,2'd1,32'h0,32'h0,32'h0,1'b0,16'h0},        // R5
        '{1'b1,1'b0,6'h39,24'hA12346,16'h2222,2'd2,32'hABC12344,32'h11112222,32'h0,1'b0,16'h0}, // R6
        '{1'b0,1'b0,6'h3D,24'hA0567C,16'h0,2'd2,32'hABC0567C,32'h0,32'hDEADBEEF,1'b1,16'hDEAD}, // R7
        '{1'b0,1'b0,6'h39,24'hA0567E,16'h0,2'd1,32'h0,32'h0,32'h0,1'b1,16'hBEEF},        // R8
        '{1'b1,1'b0,6'h09,24'hA00000,16'h5A5A,2'd0,32'h0,32'h0,32'h0,1'b0,16'h0},        // R1 bad modifier
        '{1'b1,1'b0,6'h39,24'h800000,16'h5A5A,2'd0,32'h0,32'h0,32'h0,1'b0,16'h0},        // R2 outside window
        '{1'b0,1'b1,6'h3A,24'hA00000,16'h0,2'd0,32'h0,32'h0,32'h0,1'b0,16'h0},           // R1 wide transfer
        '{1'b1,1'b0,6'h3A,24'hA00010,16'h3333,2'd1,32'h0,32'h0,32'h0,1'b0,16'h0},        // R5
        '{1'b0,1'b0,6'h3E,24'hA00020,16'h0,2'd2,32'hABC00020,32'h0,32'h12345678,1'b1,16'h1234}, // R9 read over held write
        '{1'b1,1'b0,6'h39,24'hA00030,16'h4444,2'd1,32'h0,32'h0,32'h0,1'b0,16'h0},        // R9 write over held read
        '{1'b1,1'b0,6'h39,24'hA00032,16'h5555,2'd2,32'hABC00030,32'h44445555,32'h0,1'b0,16'h0}, // R6
        '{1'b1,1'b0,6'h3E,24'hB00000,16'h0015,2'd1,32'h0,32'h0,32'h0,1'b0,16'h0},        // R3 offset=001
        '{1'b0,1'b0,6'h39,24'hA00100,16'h0,2'd2,32'h00100100,32'h0,32'hCAFEF00D,1'b1,16'hCAFE}, // R7
        '{1'b0,1'b0,6'h39,24'hA00102,16'h0,2'd1,32'h0,32'h0,32'h0,1'b1,16'hF00D}         // R8
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int done_at = -1;
        int ack_c = -1;
        int acks = 0;
        int tseen = 0;
        int lcfg = 0;
        int lbus = 0;
        logic [15:0] rd_got = '0;
        @(negedge clk);
        host_sel = 1'b1; host_we = v.we; host_wide = v.wide; host_am = v.am;
        host_addr = v.addr[23:1]; host_wdata = v.wd;
        @(negedge clk);
        host_sel = 1'b0;
        for (int c = 0; c < 30; c++) begin
            tgt_done = (c == done_at);
            if (c == done_at) tgt_rdata = v.trd;
            if (tgt_req && tseen == 0) begin
                tseen = 1;
                done_at = c + 2;
                check("R6 R7 target address", tgt_addr, v.taddr);
                check("R6 R7 target direction", {31'b0, tgt_we}, {31'b0, v.we});
                if (v.we) check("R6 target write data", tgt_wdata, v.twd);
            end
            if (led_cfg) lcfg++;
            if (led_bus) lbus++;
            if (host_ack) begin
                acks++;
                if (ack_c < 0) begin ack_c = c; rd_got = host_rdata; end
            end
            @(negedge clk);
        end
        tgt_done = 1'b0;
        check("R1 R2 R10 acknowledge count", acks, (v.kind != 2'd0) ? 1 : 0);
        check("R1 R5 R8 R9 target request seen", tseen, (v.kind == 2'd2) ? 1 : 0);
        if (v.kind == 2'd1) check("R3 R5 R8 immediate ack cycle", ack_c, 0);
        if (v.kind == 2'd2) check("R6 R7 ack after done", ack_c, done_at + 1);
        if (v.chk_rd) check("R4 R7 R8 read data", {16'b0, rd_got}, {16'b0, v.rd});
        check("R3 config indicator", lcfg, (v.kind == 2'd1 && v.we && v.addr[20]) ? 1 : 0);
        check("R11 bus indicator", lbus, (v.kind == 2'd2) ? 1 : 0);
    endtask

    function automatic vec_t mk(input logic we, input logic [23:0] a, input logic [15:0] wd,
                                input logic [1:0] kind, input logic [31:0] ta, input logic [31:0] twd);
        vec_t v;
        v = '0;
        v.we = we; v.am = 6'h39; v.addr = a; v.wd = wd; v.kind = kind; v.taddr = ta; v.twd = twd;
        return v;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int acks;
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset ack", {31'b0, host_ack}, 32'h0);
        check("R12 reset req", {31'b0, tgt_req}, 32'h0);
        check("R12 reset leds", {30'b0, led_cfg, led_bus}, 32'h0);
        check("R12 reset rdata", {16'b0, host_rdata}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R10: select during a running target read is ignored (offset is 001)
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b0; host_am = 6'h39; host_addr = 24'hA00200 >> 1;
        @(negedge clk);
        host_sel = 1'b0;
        check("R10 read request raised", {31'b0, tgt_req}, 32'h1);
        host_sel = 1'b1; host_we = 1'b1; host_addr = 24'hA00400 >> 1; host_wdata = 16'h7777;
        @(negedge clk);
        host_sel = 1'b0;
        @(negedge clk);
        check("R10 address held", tgt_addr, 32'h00100200);
        check("R10 no early ack", {31'b0, host_ack}, 32'h0);
        tgt_done = 1'b1; tgt_rdata = 32'h0BAD1CE0;
        @(negedge clk);
        tgt_done = 1'b0;
        check("R10 ack after done", {31'b0, host_ack}, 32'h1);
        check("R7 upper word", {16'b0, host_rdata}, 32'h00000BAD);
        acks = 0;
        for (int c = 0; c < 5; c++) begin @(negedge clk); if (host_ack) acks++; end
        check("R10 single ack", acks, 0);
        run_vec(mk(1'b1, 24'hA00600, 16'h6666, 2'd1, 32'h0, 32'h0));                    // R9 R10
        run_vec(mk(1'b1, 24'hA00602, 16'h8888, 2'd2, 32'h00100600, 32'h66668888));      // R10

        // R12: reset in the middle of a write pair
        run_vec(mk(1'b1, 24'hA00010, 16'h9999, 2'd1, 32'h0, 32'h0));
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R12 offset-free idle after reset", {31'b0, tgt_req}, 32'h0);
        rst_n = 1'b1;
        run_vec(mk(1'b1, 24'hA00020, 16'h1234, 2'd1, 32'h0, 32'h0));                    // R12 half cleared
        run_vec(mk(1'b1, 24'hA00022, 16'h5678, 2'd2, 32'h00000020, 32'h12345678));      // R12 offset cleared

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule